// File: doc/BRIEF.md
# Programmable Multi-Kernel Weighted Summer

This block forms four independent weighted sums over one shared set of eight unsigned input values. The inputs are group sums taken from a pixel neighbourhood: three row-direction sums, three column-direction sums, the sum for the current centre group, and a time-delayed copy of that centre sum. Every input value goes to all four summing units. Each unit keeps its own eight coefficients, so a single input set yields four filtered values in parallel. Typical kernels are edge detectors, smoothing masks and a temporal derivative.

A coefficient is a 5-bit sign-magnitude code that counts quarter steps, from -3.75 to +3.75. Results are exact signed integers in quarter units: the true weighted sum times four. The arithmetic has two register stages, one for the products and one for the sum. This gives a fixed two-clock latency from the input strobe to the output flag. Coefficients are sampled at the strobe itself, so a write made while a result is still in the pipeline only affects later strobes.

Top module: `kernel_mix_bank`

## Requirements
- R1: Input tap k occupies `in_data[k*DATA_W +: DATA_W]`. Taps 0-2 are the row sums, taps 3-5 the column sums, tap 6 the centre sum and tap 7 the delayed centre sum. All taps feed every unit.
- R2: A code has bit 4 as the sign (1 = negative) and bits 3:0 as the magnitude in quarters. Unit u reports, in `out_data[u*OUT_W +: OUT_W]` as two's complement, the sum over k of in_k x (sign ? -mag : +mag).
- R3: The output width is DATA_W+5+log2(NUM_TAPS) bits. Every tap at its maximum value with magnitude 15 gives the exact value ±NUM_TAPS x 15 x (2^DATA_W - 1). There is no wrap and no saturation.
- R4: Codes 5'b00000 and 5'b10000 both contribute zero, whatever the input value.
- R5: The units are independent. A write reaches only the entry selected by `cfg_unit` (the unit index) and `cfg_tap` (the tap index), and every other entry keeps its value.
- R6: `out_valid` is a one-cycle pulse two rising edges after the edge that samples `in_valid`. `out_valid` never rises without such a strobe.
- R7: A result uses exactly the codes present before its strobe edge. A write in the same cycle as a strobe, or after it, applies only to later strobes. Strobes in back-to-back cycles each give their own result.
- R8: `out_data` holds its value while `out_valid` is low. Input changes without a strobe, and coefficient writes, leave it unchanged.
- R9: After reset every code is zero and `out_valid` and `out_data` are zero. A strobe before any write gives zero on all units.
- R10: With +1.0 (5'b00100) on tap 6, -1.0 (5'b10100) on tap 7 and zero elsewhere, a unit outputs 4 x (centre - delayed). This is zero when the two are equal.
- R11: `rst_n` clears the block asynchronously. The internal release comes two rising edges after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_unit | input | $clog2(NUM_UNITS) | Unit index of the write |
| cfg_tap | input | $clog2(NUM_TAPS) | Tap index of the write |
| cfg_code | input | CODE_W | Sign-magnitude coefficient code |
| in_valid | input | 1 | Strobe for a new input set |
| in_data | input | NUM_TAPS*DATA_W | Packed unsigned tap values |
| out_valid | output | 1 | Result pulse |
| out_data | output | NUM_UNITS*OUT_W | Packed signed results, quarter units |

## Verification
The bench builds the block with its defaults: four units, eight taps, 12-bit inputs and 5-bit codes. This brings the exact full-scale value of ±491400 within reach, and it fills the 20-bit outputs to within one bit of their range. Four units let the bench run a different kernel in each unit and watch single-entry writes stay in their own unit. Two units carry the positive and negative full-scale kernels. One is left free for the temporal-derivative kernel while the others hold other patterns.

// File: rtl/kmb_pkg.sv
package kmb_pkg;
  localparam int KMB_CODE_W = 5;
  localparam int KMB_MAG_W  = KMB_CODE_W - 1;

  function automatic int kmb_out_w(input int data_w, input int code_w, input int taps);
    return data_w + code_w + $clog2(taps);
  endfunction
endpackage

// File: rtl/kmb_coef_bank.sv
module kmb_coef_bank #(
  parameter int NUM_TAPS = 8,
  parameter int CODE_W   = 5,
  localparam int TAP_W   = $clog2(NUM_TAPS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [TAP_W-1:0]           wr_tap,
  input  logic [CODE_W-1:0]          wr_code,
  output logic [NUM_TAPS*CODE_W-1:0] codes_q
);
  logic [NUM_TAPS*CODE_W-1:0] codes_n;

  always_comb begin
    codes_n = codes_q;
    for (int k = 0; k < NUM_TAPS; k++) begin
      if (wr_en && (wr_tap == TAP_W'(k))) begin
        codes_n[k*CODE_W +: CODE_W] = wr_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codes_q <= '0;
    end else if (wr_en) begin
      codes_q <= codes_n;
    end
  end
endmodule

// File: rtl/kmb_tap_mult.sv
module kmb_tap_mult #(
  parameter int DATA_W  = 12,
  parameter int CODE_W  = 5,
  localparam int MAG_W  = CODE_W - 1,
  localparam int PROD_W = DATA_W + MAG_W + 1
) (
  input  logic [DATA_W-1:0]        tap_val,
  input  logic [CODE_W-1:0]        code,
  output logic signed [PROD_W-1:0] prod
);
  logic [MAG_W-1:0]        mag;
  logic                    neg;
  logic [PROD_W-2:0]       prod_mag;
  logic signed [PROD_W-1:0] prod_pos;

  always_comb begin
    mag      = code[MAG_W-1:0];
    neg      = code[CODE_W-1];
    prod_mag = (PROD_W-1)'(tap_val) * (PROD_W-1)'(mag);
    prod_pos = $signed({1'b0, prod_mag});
    prod     = neg ? -prod_pos : prod_pos;
  end
endmodule

// File: rtl/kmb_lane.sv
module kmb_lane #(
  parameter int NUM_TAPS = 8,
  parameter int DATA_W   = 12,
  parameter int CODE_W   = 5,
  localparam int PROD_W  = DATA_W + CODE_W,
  localparam int SUM_W   = PROD_W + $clog2(NUM_TAPS),
  localparam int EXT_W   = SUM_W - PROD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_prod,
  input  logic                       load_sum,
  input  logic [NUM_TAPS*DATA_W-1:0] taps_in,
  input  logic [NUM_TAPS*CODE_W-1:0] codes,
  output logic [SUM_W-1:0]           sum_q
);
  logic [NUM_TAPS*PROD_W-1:0] prod_d;
  logic [NUM_TAPS*PROD_W-1:0] prod_q;
  logic [NUM_TAPS*PROD_W-1:0] prod_n;
  logic [SUM_W-1:0]           sum_d;
  logic [SUM_W-1:0]           sum_n;

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    logic signed [PROD_W-1:0] p;
    kmb_tap_mult #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_mult (
      .tap_val (taps_in[k*DATA_W +: DATA_W]),
      .code    (codes[k*CODE_W +: CODE_W]),
      .prod    (p)
    );
    assign prod_d[k*PROD_W +: PROD_W] = p;
  end

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      sum_d = sum_d + {{EXT_W{prod_q[k*PROD_W + PROD_W - 1]}}, prod_q[k*PROD_W +: PROD_W]};
    end
  end

  always_comb begin
    prod_n = load_prod ? prod_d : prod_q;
    sum_n  = load_sum  ? sum_d  : sum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      sum_q  <= '0;
    end else begin
      prod_q <= prod_n;
      sum_q  <= sum_n;
    end
  end
endmodule

// File: rtl/kernel_mix_bank.sv
module kernel_mix_bank #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_TAPS  = 8,
  parameter int DATA_W    = 12,
  parameter int CODE_W    = kmb_pkg::KMB_CODE_W,
  localparam int OUT_W    = kmb_pkg::kmb_out_w(DATA_W, CODE_W, NUM_TAPS),
  localparam int UNIT_W   = $clog2(NUM_UNITS),
  localparam int TAP_W    = $clog2(NUM_TAPS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [UNIT_W-1:0]            cfg_unit,
  input  logic [TAP_W-1:0]             cfg_tap,
  input  logic [CODE_W-1:0]            cfg_code,
  input  logic                         in_valid,
  input  logic [NUM_TAPS*DATA_W-1:0]   in_data,
  output logic                         out_valid,
  output logic [NUM_UNITS*OUT_W-1:0]   out_data
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       stage1_q;
  logic       stage2_q;
  logic       stage1_n;
  logic       stage2_n;
  logic [NUM_UNITS*NUM_TAPS*CODE_W-1:0] code_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_comb begin
    stage1_n = in_valid;
    stage2_n = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= stage1_n;
      stage2_q <= stage2_n;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic                       wr_sel;
    logic [NUM_TAPS*CODE_W-1:0] codes;

    assign wr_sel = cfg_we && (cfg_unit == UNIT_W'(u));

    kmb_coef_bank #(.NUM_TAPS(NUM_TAPS), .CODE_W(CODE_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_sel),
      .wr_tap  (cfg_tap),
      .wr_code (cfg_code),
      .codes_q (codes)
    );

    kmb_lane #(.NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .load_prod (in_valid),
      .load_sum  (stage1_q),
      .taps_in   (in_data),
      .codes     (codes),
      .sum_q     (out_data[u*OUT_W +: OUT_W])
    );

    assign code_all[u*NUM_TAPS*CODE_W +: NUM_TAPS*CODE_W] = codes;
  end

  assign out_valid = stage2_q;
endmodule

// File: rtl/kmb_checker.sv
module kmb_checker #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_TAPS  = 8,
  parameter int DATA_W    = 12,
  parameter int CODE_W    = 5,
  localparam int OUT_W    = DATA_W + CODE_W + $clog2(NUM_TAPS),
  localparam int UNIT_W   = $clog2(NUM_UNITS),
  localparam int TAP_W    = $clog2(NUM_TAPS)
) (
  input logic                                 clk,
  input logic                                 rst_ok,
  input logic                                 cfg_we,
  input logic [UNIT_W-1:0]                    cfg_unit,
  input logic [TAP_W-1:0]                     cfg_tap,
  input logic [CODE_W-1:0]                    cfg_code,
  input logic                                 in_valid,
  input logic                                 out_valid,
  input logic [NUM_UNITS*OUT_W-1:0]           out_data,
  input logic [NUM_UNITS*NUM_TAPS*CODE_W-1:0] code_all
);
  localparam longint MAX_MAG = (longint'(1) << (CODE_W - 1)) - 1;
  localparam longint LIMIT   = longint'(NUM_TAPS) * MAX_MAG * ((longint'(1) << DATA_W) - 1);

  int wr_idx;
  assign wr_idx = int'(cfg_unit) * NUM_TAPS + int'(cfg_tap);

  // R6: a strobe always yields a pulse two edges later
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> ##1 out_valid);

  // R6: no pulse without a strobe two edges earlier
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid |-> $past(in_valid, 2));

  // R8: results hold while the flag is low
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !out_valid |-> $stable(out_data));

  // R5: a write lands in exactly the addressed entry
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_we |=> (code_all[$past(wr_idx)*CODE_W +: CODE_W] == $past(cfg_code)));

  // R5: without a write the coefficient store is unchanged
  p_store_quiet_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    !cfg_we |=> $stable(code_all));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_rng
    // R3: no result leaves the exact full-scale range
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_ok)
      out_valid |-> (longint'($signed(out_data[u*OUT_W +: OUT_W])) <= LIMIT &&
                     longint'($signed(out_data[u*OUT_W +: OUT_W])) >= -LIMIT));
  end
endmodule

bind kernel_mix_bank kmb_checker #(
  .NUM_UNITS (NUM_UNITS),
  .NUM_TAPS  (NUM_TAPS),
  .DATA_W    (DATA_W),
  .CODE_W    (CODE_W)
) u_kmb_checker (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .cfg_we    (cfg_we),
  .cfg_unit  (cfg_unit),
  .cfg_tap   (cfg_tap),
  .cfg_code  (cfg_code),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .code_all  (code_all)
);

// File: tb/kernel_mix_bank_bench.sv
`timescale 1ns/1ps
module kernel_mix_bank_bench;
  localparam int NU = 4;
  localparam int NT = 8;
  localparam int DW = 12;
  localparam int CW = 5;
  localparam int OW = DW + CW + $clog2(NT);

  logic              clk;
  logic              rst_n;
  logic              cfg_we;
  logic [1:0]        cfg_unit;
  logic [2:0]        cfg_tap;
  logic [CW-1:0]     cfg_code;
  logic              in_valid;
  logic [NT*DW-1:0]  in_data;
  logic              out_valid;
  logic [NU*OW-1:0]  out_data;

  int n_checks;
  int n_fails;
  int mdl [NU][NT];

  kernel_mix_bank #(.NUM_UNITS(NU), .NUM_TAPS(NT), .DATA_W(DW), .CODE_W(CW)) u_kernel_mix_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_unit(cfg_unit), .cfg_tap(cfg_tap),
    .cfg_code(cfg_code), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint get_out(input int u);
    return longint'($signed(out_data[u*OW +: OW]));
  endfunction

  function automatic longint expect_sum(input int u, input int d[NT]);
    longint acc = 0;
    for (int k = 0; k < NT; k++) begin
      int mag = mdl[u][k] & 15;
      acc += ((mdl[u][k] & 16) != 0) ? -longint'(d[k]) * mag : longint'(d[k]) * mag;
    end
    return acc;
  endfunction

  task automatic wr(input int u, input int t, input int code);
    cfg_we = 1'b1; cfg_unit = 2'(u); cfg_tap = 3'(t); cfg_code = CW'(code);
    mdl[u][t] = code;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_data(input int d[NT]);
    for (int k = 0; k < NT; k++) in_data[k*DW +: DW] = DW'(d[k]);
  endtask

  // strobe, then check latency and all four units
  task automatic fire_check(input string tag, input int d[NT]);
    longint e [NU];
    for (int u = 0; u < NU; u++) e[u] = expect_sum(u, d);
    put_data(d);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R6 early"}, longint'(out_valid), 0);
    @(negedge clk);
    check({tag, " R6 pulse"}, longint'(out_valid), 1);
    for (int u = 0; u < NU; u++) check({tag, " R2 value"}, get_out(u), e[u]);
    @(negedge clk);
    check({tag, " R6 single"}, longint'(out_valid), 0);
  endtask

  task automatic t_reset;
    int d[NT] = '{100, 200, 300, 400, 500, 600, 700, 800};
    check("R9 valid at reset", longint'(out_valid), 0);
    for (int u = 0; u < NU; u++) check("R9 data at reset", get_out(u), 0);
    fire_check("R9 zero codes", d);
  endtask

  task automatic t_taps;
    int d[NT] = '{1, 10, 100, 1000, 7, 33, 250, 4000};
    for (int k = 0; k < NT; k++) begin
      wr(0, k, k + 1);
      wr(1, k, 16 | (15 - k));
      wr(2, k, (k % 2 == 0) ? 5 : 16 | 3);
      wr(3, k, (k == 3) ? 9 : 0);
    end
    fire_check("R1 tap order", d);
    d = '{4095, 0, 17, 2, 2048, 99, 1, 300};
    fire_check("R2 second pattern", d);
  endtask

  task automatic t_zero;
    int d[NT] = '{4095, 4095, 12, 12, 12, 12, 12, 12};
    wr(2, 0, 5'b10000);
    wr(2, 1, 5'b00000);
    for (int k = 2; k < NT; k++) wr(2, k, 0);
    fire_check("R4 zero codes", d);
    check("R4 unit2 zero", get_out(2), 0);
  endtask

  task automatic t_full;
    int d[NT] = '{4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095};
    for (int k = 0; k < NT; k++) begin
      wr(0, k, 15);
      wr(1, k, 31);
    end
    fire_check("R3 full scale", d);
    check("R3 positive max", get_out(0), 491400);
    check("R3 negative max", get_out(1), -491400);
  endtask

  task automatic t_indep;
    int d[NT] = '{3, 5, 7, 11, 13, 17, 19, 23};
    wr(3, 5, 16 | 6);
    fire_check("R5 single entry", d);
    check("R5 unit0 untouched", get_out(0), longint'(15) * (3+5+7+11+13+17+19+23));
  endtask

  task automatic t_midflight;
    int da[NT] = '{10, 10, 10, 10, 10, 10, 10, 10};
    int db[NT] = '{20, 20, 20, 20, 20, 20, 20, 20};
    longint ea, eb;
    ea = expect_sum(0, da);
    put_data(da);
    in_valid = 1'b1;
    cfg_we = 1'b1; cfg_unit = 2'd0; cfg_tap = 3'd0; cfg_code = 5'b10010;
    @(negedge clk);
    mdl[0][0] = 5'b10010;
    eb = expect_sum(0, db);
    cfg_we = 1'b0;
    put_data(db);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 first uses old codes", get_out(0), ea);
    check("R7 first pulse", longint'(out_valid), 1);
    @(negedge clk);
    check("R7 second uses new codes", get_out(0), eb);
    check("R7 second pulse", longint'(out_valid), 1);
    @(negedge clk);
  endtask

  task automatic t_hold;
    longint held [NU];
    for (int u = 0; u < NU; u++) held[u] = get_out(u);
    in_data = '1;
    wr(0, 3, 5'b01111);
    wr(1, 2, 5'b00001);
    repeat (3) @(negedge clk);
    check("R8 no pulse", longint'(out_valid), 0);
    for (int u = 0; u < NU; u++) check("R8 held", get_out(u), held[u]);
  endtask

  task automatic t_deriv;
    int d[NT] = '{900, 800, 700, 600, 500, 400, 1234, 1234};
    for (int k = 0; k < 6; k++) wr(1, k, 0);
    wr(1, 6, 5'b00100);
    wr(1, 7, 5'b10100);
    fire_check("R10 equal", d);
    check("R10 zero derivative", get_out(1), 0);
    d[6] = 100; d[7] = 60;
    fire_check("R10 change", d);
    check("R10 derivative", get_out(1), 160);
  endtask

  task automatic t_async_reset;
    #3 rst_n = 1'b0;
    #2;
    check("R11 async clear", longint'(get_out(0)), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NT; k++) for (int u = 0; u < NU; u++) mdl[u][k] = 0;
    @(negedge clk);
    in_valid = 1'b1;
    put_data('{5, 5, 5, 5, 5, 5, 5, 5});
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 strobe inside release window ignored", longint'(out_valid), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    n_checks = 0; n_fails = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_unit = '0; cfg_tap = '0; cfg_code = '0;
    in_valid = 1'b0; in_data = '0;
    for (int u = 0; u < NU; u++) for (int k = 0; k < NT; k++) mdl[u][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_taps();
    t_zero();
    t_full();
    t_indep();
    t_midflight();
    t_hold();
    t_deriv();
    t_async_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule